// File: doc/BRIEF.md
# Segment-Register Effective-Address Extender

This block widens a 32-bit effective address into a 52-bit extended virtual address through a bank of sixteen segment registers. The top four bits of the incoming address pick one register. That register holds a 24-bit segment identifier. The identifier is placed directly above the remaining 28 offset bits; it is not added to them. Each segment therefore spans a 256 MB window of the virtual space. The result goes, registered, to a downstream TLB that is not part of this block.

Privileged software loads one segment register at a time through a write port. A combinational read port returns any register, so its contents can be saved on a context switch. Isolation between contexts depends only on which identifiers each context loads. Two contexts that hold the same identifier reach the same virtual segment. No address-space tag exists, and nothing needs to be flushed when the context changes.

Top module: `seg_ext_xlate`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_va` is 0, and every segment register reads back as 0.
- R2: `out_valid` is high in the cycle after a rising clock edge that samples `in_valid` high. It is low in the cycle after an edge that samples `in_valid` low.
- R3: When an edge samples `in_valid` high, `out_va` after that edge equals {segment register[`in_ea[31:28]`], `in_ea[27:0]`}. The identifier fills bits 51:28 and the offset fills bits 27:0.
- R4: When an edge samples `in_valid` low, `out_va` keeps its previous value.
- R5: A clock edge that samples `wr_en` high loads `wr_sid` into register `wr_idx`. The other fifteen registers keep their values.
- R6: A translation sampled at the same edge as a write to the register it selects uses the value from before the write. Translations at later edges use the new value.
- R7: `rd_sid` shows register `rd_idx` without delay, including a value written at the most recent edge.
- R8: Two indexes that hold the same identifier give the same bits 51:28 for equal offsets. This is how a segment is shared between contexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Effective address present this cycle |
| in_ea | input | 32 | Effective address |
| wr_en | input | 1 | Segment register write strobe |
| wr_idx | input | 4 | Register to write |
| wr_sid | input | 24 | Identifier to write |
| rd_idx | input | 4 | Register to read |
| rd_sid | output | 24 | Identifier held in register `rd_idx` |
| out_valid | output | 1 | Extended address valid |
| out_va | output | 52 | Extended virtual address |

## Verification
The translation result and its valid flag are due one clock edge after the inputs are sampled. Register writes appear on the read port right after the writing edge, and a write has no effect on a translation sampled at the same edge. The bench drives inputs on the falling edge and reads results 1 ns after the next rising edge, so each check falls inside the cycle where the result is due. Reset is checked while it is held low, with no clock edge needed.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned SEG_EA_W  = 32;
  localparam int unsigned SEG_IDX_W = 4;
  localparam int unsigned SEG_SID_W = 24;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SID_W = 24,
  localparam int unsigned NSEG = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SID_W-1:0]            wr_sid,
  output logic [NSEG-1:0][SID_W-1:0]  sid_all
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic             load;
    logic [SID_W-1:0] sid_d;
    logic [SID_W-1:0] sid_q;

    always_comb begin
      load  = wr_en && (wr_idx == IDX_W'(g));
      sid_d = wr_sid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sid_q <= '0;
      else if (load) sid_q <= sid_d;
    end

    assign sid_all[g] = sid_q;
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SID_W = 24,
  localparam int unsigned NSEG = 1 << IDX_W
) (
  input  logic [NSEG-1:0][SID_W-1:0] sid_all,
  input  logic [IDX_W-1:0]           sel,
  output logic [SID_W-1:0]           sid
);
  always_comb sid = sid_all[sel];
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int unsigned SID_W = 24,
  parameter int unsigned OFS_W = 28,
  localparam int unsigned VA_W = SID_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SID_W-1:0] sid,
  input  logic [OFS_W-1:0] ofs,
  output logic             out_valid,
  output logic [VA_W-1:0]  out_va
);
  logic            vld_d;
  logic            va_en;
  logic [VA_W-1:0] va_d;

  always_comb begin
    vld_d = in_valid;
    va_en = in_valid;
    va_d  = {sid, ofs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_va <= '0;
    else if (va_en) out_va <= va_d;
  end
endmodule

// File: rtl/seg_ext_xlate.sv
module seg_ext_xlate #(
  parameter int unsigned EA_W  = seg_pkg::SEG_EA_W,
  parameter int unsigned IDX_W = seg_pkg::SEG_IDX_W,
  parameter int unsigned SID_W = seg_pkg::SEG_SID_W,
  localparam int unsigned NSEG  = 1 << IDX_W,
  localparam int unsigned OFS_W = EA_W - IDX_W,
  localparam int unsigned VA_W  = SID_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EA_W-1:0]  in_ea,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SID_W-1:0] wr_sid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SID_W-1:0] rd_sid,
  output logic             out_valid,
  output logic [VA_W-1:0]  out_va
);
  logic [NSEG-1:0][SID_W-1:0] sid_all;
  logic [SID_W-1:0]           xl_sid;

  seg_bank #(.IDX_W(IDX_W), .SID_W(SID_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sid(wr_sid), .sid_all(sid_all)
  );

  seg_pick #(.IDX_W(IDX_W), .SID_W(SID_W)) u_pick_xl (
    .sid_all(sid_all), .sel(in_ea[EA_W-1:OFS_W]), .sid(xl_sid)
  );

  seg_pick #(.IDX_W(IDX_W), .SID_W(SID_W)) u_pick_rd (
    .sid_all(sid_all), .sel(rd_idx), .sid(rd_sid)
  );

  seg_out_stage #(.SID_W(SID_W), .OFS_W(OFS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sid(xl_sid),
    .ofs(in_ea[OFS_W-1:0]), .out_valid(out_valid), .out_va(out_va)
  );
endmodule

// File: rtl/seg_ext_chk.sv
module seg_ext_chk #(
  parameter int unsigned EA_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SID_W = 24,
  localparam int unsigned OFS_W = EA_W - IDX_W,
  localparam int unsigned VA_W  = SID_W + OFS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [EA_W-1:0]  in_ea,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [SID_W-1:0] wr_sid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [SID_W-1:0] rd_sid,
  input logic             out_valid,
  input logic [VA_W-1:0]  out_va
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!out_valid && out_va == '0 && rd_sid == '0);
    end
  end

  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_va[OFS_W-1:0] == $past(in_ea[OFS_W-1:0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_va));

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) || (rd_sid == $past(wr_sid)));

  p_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_idx == in_ea[EA_W-1:OFS_W]) |=>
      out_va[VA_W-1:OFS_W] == $past(rd_sid));
endmodule

bind seg_ext_xlate seg_ext_chk #(.EA_W(EA_W), .IDX_W(IDX_W), .SID_W(SID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ea(in_ea),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_sid(wr_sid), .rd_idx(rd_idx),
  .rd_sid(rd_sid), .out_valid(out_valid), .out_va(out_va)
);

// File: tb/sim_seg_ext_xlate.sv
`timescale 1ns/1ps
module sim_seg_ext_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_ea;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [23:0] wr_sid;
  logic [3:0]  rd_idx;
  logic [23:0] rd_sid;
  logic        out_valid;
  logic [51:0] out_va;

  int total = 0;
  int bad = 0;
  logic [23:0] mdl [16];
  logic [51:0] last_va;

  always #2 clk = ~clk;

  seg_ext_xlate u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ea(in_ea),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sid(wr_sid), .rd_idx(rd_idx),
    .rd_sid(rd_sid), .out_valid(out_valid), .out_va(out_va)
  );

  task automatic chk(input string req, input logic [51:0] act, input logic [51:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_seg(input logic [3:0] idx, input logic [23:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sid = v;
    @(posedge clk); #1;
    mdl[idx] = v;
    wr_en = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] ea);
    @(negedge clk);
    in_valid = 1'b1; in_ea = ea;
    @(posedge clk); #1;
    chk("R2", 52'(out_valid), 52'd1);
    chk("R3", out_va, {mdl[ea[31:28]], ea[27:0]});
    in_valid = 1'b0;
  endtask

  function automatic logic [23:0] pat(input int i, input int k);
    return 24'((i * 24'h0F1E2D + k * 24'h13579B) ^ 24'hA5A5A5);
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_ea = '0;
    wr_en = 1'b0; wr_idx = '0; wr_sid = '0; rd_idx = '0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    #1;
    // R1: reset state
    chk("R1", 52'(out_valid), 52'd0);
    chk("R1", out_va, 52'd0);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #1;
      chk("R1", 52'(rd_sid), 52'd0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R5 and R7: write each register and read all back
    for (int i = 0; i < 16; i++) begin
      write_seg(4'(i), pat(i, 1));
      rd_idx = 4'(i); #0.1;
      chk("R7", 52'(rd_sid), 52'(mdl[i]));
    end
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #0.1;
      chk("R5", 52'(rd_sid), 52'(mdl[i]));
    end

    // R3: every index with several offsets
    for (int i = 0; i < 16; i++) begin
      xlate({4'(i), 28'h0000000});
      xlate({4'(i), 28'hFFFFFFF});
      xlate({4'(i), 28'(i * 28'h1234567 + 28'h0ABCDEF)});
    end

    // R4: idle cycles hold the result
    last_va = out_va;
    repeat (4) begin
      @(posedge clk); #1;
      chk("R2", 52'(out_valid), 52'd0);
      chk("R4", out_va, last_va);
    end

    // R6: write and translate the same register at the same edge
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_ea = {4'(i), 28'h5A5A5A5};
      wr_en = 1'b1; wr_idx = 4'(i); wr_sid = pat(i, 2);
      @(posedge clk); #1;
      chk("R6", out_va, {mdl[i], 28'h5A5A5A5});
      mdl[i] = pat(i, 2);
      wr_en = 1'b0; in_valid = 1'b0;
      xlate({4'(i), 28'h5A5A5A5});
    end

    // R8: two indexes sharing an identifier
    write_seg(4'd3, 24'hC0FFEE);
    write_seg(4'd12, 24'hC0FFEE);
    xlate(32'h3ABCDEF0);
    last_va = out_va;
    xlate(32'hCABCDEF0);
    chk("R8", out_va, last_va);

    // R1: reset asserted mid-run clears everything
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1", 52'(out_valid), 52'd0);
    chk("R1", out_va, 52'd0);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #0.1;
      chk("R1", 52'(rd_sid), 52'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule